// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Masked Output Writes and a Merged Interrupt

The block drives and samples sixteen general-purpose pins through a small word-addressed register bus. Software sets each pin's direction and output level. A write to the output register carries its own per-pin write mask, so one pin can change without a read-modify-write sequence that another thread could interrupt. Pin levels pass through a two-stage synchronizer. They can then be read back and feed the interrupt logic.

The eight low pins each present their synchronized level on a separate request line to an external interrupt controller. The eight high pins share one active-high request. Each of those pins is gated by its own enable bit, and the gated levels are ORed together. A two-bit control register lets software hold the block in reset or stop its clock. When the block is not running, every other register is unreachable.

Top module: `gpio16_shared_irq`

## Requirements
- R1: After the hardware reset, the control, direction, output and interrupt-enable registers are 0, `pin_oe`, `pin_out`, `irq_line` and `irq_shared` are all 0, and a read of word 0 returns 0.
- R2: Word 0 is the control register. Bit 0 runs the block clock and bit 1 holds the block in reset. The block is running only when the register holds 1. The register is always writable and reads back its two bits. With value 0, meaning clock stopped and no reset, the other registers keep their contents, and those contents are visible again once the value is 1.
- R3: While control bit 1 is set, the direction, output and interrupt-enable registers are cleared to 0 and stay at 0. Writes to them are ignored during that time.
- R4: While the block is not running, writes to words 1, 2 and 4 have no effect, and reads of words 1 to 7 return 0.
- R5: Word 1 is the direction register. Bit i set to 1 makes pin i an output, so `pin_oe[i]` is 1. The register reads back the value last written.
- R6: A write to word 2 updates output bit i to data bit i only where data bit 16+i is 1. Other bits keep their value. A read of word 2 returns the output values in bits 15:0 with zeros above, and `pin_out` follows the register.
- R7: Word 3 returns the synchronized level of `pin_in` in bits 15:0. A change on `pin_in` is not visible after one rising clock edge and is visible after the second. Writes to word 3 are ignored.
- R8: `irq_line[i]` for pins 0 to 7 equals the synchronized level of pin i, independent of the interrupt-enable register. It is 0 while the block is not running.
- R9: Word 4 bits 7:0 are the enable bits for pins 8 to 15, in that order. `irq_shared` is the OR over those pins of the synchronized level ANDed with the enable bit. It is 0 while the block is not running.
- R10: The interrupt-enable register keeps only bits 7:0 of a write, and a read returns them with zeros above.
- R11: Words 5 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| rd_en | input | 1 | Register read enable; rdata is 0 when low |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| pin_in | input | 16 | Pad input levels, asynchronous |
| pin_out | output | 16 | Pad output levels |
| pin_oe | output | 16 | Pad output enables, 1 = drive |
| irq_line | output | 8 | Per-pin interrupt requests for pins 0 to 7 |
| irq_shared | output | 1 | Merged interrupt request for pins 8 to 15 |

## Verification
The hardest state to reach is a stopped clock with nonzero contents held underneath it. Reads return 0 in that state, so the port shows nothing of what the registers hold. The stimulus programs the direction register and stops the clock, then confirms that the pad enables hold while reads return 0. It restarts the clock and reads the held value back, and a separate pass through the reset setting shows the contrast. The shared interrupt is driven by letting an enabled pin stay low while a disabled pin sits high, and then raising the enabled pin through the synchronizer.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] WORD_CTL   = 3'd0;
  localparam logic [ADDR_W-1:0] WORD_DIR   = 3'd1;
  localparam logic [ADDR_W-1:0] WORD_OUT   = 3'd2;
  localparam logic [ADDR_W-1:0] WORD_STATE = 3'd3;
  localparam logic [ADDR_W-1:0] WORD_IEN   = 3'd4;

  // control encoding: bit 0 clock run, bit 1 hold in reset
  localparam logic [1:0] CTL_RUN = 2'b01;
endpackage

// File: rtl/gpio_ctl.sv
module gpio_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctl,
  input  logic [1:0] wdata,
  output logic [1:0] ctl_q,
  output logic       active,
  output logic       clear
);
  import gpio_pkg::*;

  logic [1:0] ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl) ctl_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= 2'b00;
    else        ctl_q <= ctl_d;
  end

  assign active = (ctl_q == CTL_RUN);
  assign clear  = ctl_q[1];

  // R2: writing the run value makes the block active on the next cycle
  assert_run_value_activates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && wdata == CTL_RUN) |=> active);

  // R3: a reset request never leaves the block active
  assert_reset_blocks_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && wdata[1]) |=> !active);
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic stage1_q, stage2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q <= 1'b0;
        stage2_q <= 1'b0;
      end else begin
        stage1_q <= async_in[i];
        stage2_q <= stage1_q;
      end
    end
    assign sync_out[i] = stage2_q;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned IEN_W    = 8,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      active,
  input  logic                      clear,
  input  logic                      wr_en,
  input  logic [gpio_pkg::ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [NUM_PINS-1:0]       dir_q,
  output logic [NUM_PINS-1:0]       out_q,
  output logic [IEN_W-1:0]          ien_q
);
  import gpio_pkg::*;

  localparam int unsigned MASK_LSB = DATA_W / 2;

  logic [NUM_PINS-1:0] dir_d, out_d, wr_mask, wr_val;
  logic [IEN_W-1:0]    ien_d;
  logic                wr_ok;

  assign wr_ok   = wr_en && active;
  assign wr_mask = wdata[MASK_LSB +: NUM_PINS];
  assign wr_val  = wdata[NUM_PINS-1:0];

  always_comb begin
    dir_d = dir_q;
    out_d = out_q;
    ien_d = ien_q;
    if (clear) begin
      dir_d = '0;
      out_d = '0;
      ien_d = '0;
    end else if (wr_ok) begin
      case (addr)
        WORD_DIR: dir_d = wr_val;
        WORD_OUT: out_d = (out_q & ~wr_mask) | (wr_val & wr_mask);
        WORD_IEN: ien_d = wdata[IEN_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      ien_q <= '0;
    end else begin
      dir_q <= dir_d;
      out_q <= out_d;
      ien_q <= ien_d;
    end
  end

  // R3: the reset request empties every register
  assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (dir_q == '0 && out_q == '0 && ien_q == '0));

  // R4: writes while stopped leave contents untouched
  assert_stopped_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !active && !clear) |=> ($stable(dir_q) && $stable(out_q) && $stable(ien_q)));

  // R6: unmasked output bits keep their previous value
  assert_unmasked_bits_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr == WORD_OUT) |=>
      ((out_q & ~$past(wr_mask)) == ($past(out_q) & ~$past(wr_mask))));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned SPLIT    = 8,
  localparam int unsigned IEN_W   = NUM_PINS - SPLIT
) (
  input  logic                active,
  input  logic [NUM_PINS-1:0] level,
  input  logic [IEN_W-1:0]    ien,
  output logic [SPLIT-1:0]    irq_line,
  output logic                irq_shared
);
  logic [IEN_W-1:0] gated;

  for (genvar i = 0; i < IEN_W; i++) begin : g_gate
    assign gated[i] = level[SPLIT+i] & ien[i];
  end

  assign irq_line   = active ? level[SPLIT-1:0] : '0;
  assign irq_shared = active & (|gated);
endmodule

// File: rtl/gpio16_shared_irq.sv
module gpio16_shared_irq #(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned SPLIT    = 8,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [gpio_pkg::ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  input  logic [NUM_PINS-1:0]         pin_in,
  output logic [NUM_PINS-1:0]         pin_out,
  output logic [NUM_PINS-1:0]         pin_oe,
  output logic [SPLIT-1:0]            irq_line,
  output logic                        irq_shared
);
  import gpio_pkg::*;

  localparam int unsigned IEN_W = NUM_PINS - SPLIT;

  logic                rst_meta_q, rst_n_s;
  logic [1:0]          ctl_q;
  logic                active, clear;
  logic [NUM_PINS-1:0] level, dir_q, out_q;
  logic [IEN_W-1:0]    ien_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  gpio_ctl u_ctl (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wr_ctl (wr_en && addr == WORD_CTL),
    .wdata  (wdata[1:0]),
    .ctl_q  (ctl_q),
    .active (active),
    .clear  (clear)
  );

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .async_in (pin_in),
    .sync_out (level)
  );

  gpio_regs #(.NUM_PINS(NUM_PINS), .IEN_W(IEN_W), .DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .active (active),
    .clear  (clear),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .dir_q  (dir_q),
    .out_q  (out_q),
    .ien_q  (ien_q)
  );

  gpio_irq #(.NUM_PINS(NUM_PINS), .SPLIT(SPLIT)) u_irq (
    .active     (active),
    .level      (level),
    .ien        (ien_q),
    .irq_line   (irq_line),
    .irq_shared (irq_shared)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == WORD_CTL) begin
        rdata[1:0] = ctl_q;
      end else if (active) begin
        case (addr)
          WORD_DIR:   rdata[NUM_PINS-1:0] = dir_q;
          WORD_OUT:   rdata[NUM_PINS-1:0] = out_q;
          WORD_STATE: rdata[NUM_PINS-1:0] = level;
          WORD_IEN:   rdata[IEN_W-1:0]    = ien_q;
          default:    rdata = '0;
        endcase
      end
    end
  end

  // R4: a stopped block reads zero everywhere except the control word
  assert_stopped_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && !active && addr != WORD_CTL) |-> rdata == '0);

  // R8: no per-pin request while stopped
  assert_lines_quiet_when_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !active |-> irq_line == '0);

  // R9: shared request needs at least one enable bit and a running block
  assert_shared_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_shared |-> (active && ien_q != '0));

  // R11: unmapped words always read zero
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && addr > WORD_IEN) |-> rdata == '0);
endmodule

// File: tb/tb_gpio16_shared_irq.sv
module tb_gpio16_shared_irq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic [15:0] pin_in, pin_out, pin_oe;
  logic [7:0]  irq_line;
  logic        irq_shared;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio16_shared_irq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_line(irq_line), .irq_shared(irq_shared)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_read(3'd0, v);
    check("R1 ctl after reset", v, 32'h0);
    check("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
    check("R1 pin_out", {16'h0, pin_out}, 32'h0);
    check("R1 irq", {23'h0, irq_shared, irq_line}, 32'h0);
  endtask

  task automatic t_stopped_writes();
    logic [31:0] v;
    bus_write(3'd1, 32'h0000_FFFF);
    bus_read(3'd1, v);
    check("R4 dir read while stopped", v, 32'h0);
    check("R4 pin_oe after stopped write", {16'h0, pin_oe}, 32'h0);
    bus_write(3'd0, 32'h1);
    bus_read(3'd0, v);
    check("R2 ctl readback run", v, 32'h1);
    bus_read(3'd1, v);
    check("R4 dir kept zero", v, 32'h0);
  endtask

  task automatic t_direction();
    logic [31:0] v;
    bus_write(3'd1, 32'h0000_A5C3);
    bus_read(3'd1, v);
    check("R5 dir readback", v, 32'h0000_A5C3);
    check("R5 pin_oe", {16'h0, pin_oe}, 32'h0000_A5C3);
  endtask

  task automatic t_masked_out();
    logic [31:0] v;
    bus_write(3'd2, 32'hFFFF_1234);
    check("R6 full mask write", {16'h0, pin_out}, 32'h0000_1234);
    bus_write(3'd2, 32'h00F0_0000);
    check("R6 clear nibble", {16'h0, pin_out}, 32'h0000_1204);
    bus_write(3'd2, 32'h8001_FFFF);
    bus_read(3'd2, v);
    check("R6 set two bits readback", v, 32'h0000_9205);
    bus_write(3'd2, 32'h0000_FFFF);
    check("R6 zero mask no change", {16'h0, pin_out}, 32'h0000_9205);
  endtask

  task automatic t_pin_state();
    logic [31:0] v;
    @(negedge clk);
    pin_in = 16'h5A3C;
    @(negedge clk);
    bus_read(3'd3, v);
    check("R7 not visible after one edge", v, 32'h0);
    @(negedge clk);
    bus_read(3'd3, v);
    check("R7 visible after two edges", v, 32'h0000_5A3C);
    bus_write(3'd3, 32'hFFFF_FFFF);
    bus_read(3'd3, v);
    check("R7 write ignored", v, 32'h0000_5A3C);
    bus_write(3'd5, 32'hFFFF_FFFF);
    bus_read(3'd5, v);
    check("R11 unmapped read", v, 32'h0);
    bus_read(3'd1, v);
    check("R11 dir untouched", v, 32'h0000_A5C3);
  endtask

  task automatic t_irqs();
    logic [31:0] v;
    check("R8 lines follow pins", {24'h0, irq_line}, 32'h0000_003C);
    check("R9 shared off with no enables", {31'h0, irq_shared}, 32'h0);
    bus_write(3'd4, 32'h0000_0010);
    check("R9 enabled high pin 12", {31'h0, irq_shared}, 32'h1);
    check("R8 lines unaffected by enables", {24'h0, irq_line}, 32'h0000_003C);
    bus_write(3'd4, 32'hFFFF_FF04);
    check("R9 enabled pin 10 low", {31'h0, irq_shared}, 32'h0);
    bus_read(3'd4, v);
    check("R10 enable readback", v, 32'h0000_0004);
    @(negedge clk);
    pin_in = 16'h5E3C;
    @(negedge clk);
    check("R9 not yet after one edge", {31'h0, irq_shared}, 32'h0);
    @(negedge clk);
    check("R9 pin 10 rises", {31'h0, irq_shared}, 32'h1);
  endtask

  task automatic t_clock_hold();
    logic [31:0] v;
    bus_write(3'd1, 32'h0000_00FF);
    bus_write(3'd0, 32'h0);
    check("R2 pin_oe held with clock off", {16'h0, pin_oe}, 32'h0000_00FF);
    bus_read(3'd1, v);
    check("R4 dir read zero with clock off", v, 32'h0);
    check("R9 shared quiet with clock off", {31'h0, irq_shared}, 32'h0);
    check("R8 lines quiet with clock off", {24'h0, irq_line}, 32'h0);
    bus_write(3'd0, 32'h1);
    bus_read(3'd1, v);
    check("R2 dir kept across clock stop", v, 32'h0000_00FF);
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    bus_write(3'd0, 32'h3);
    @(negedge clk);
    check("R3 pin_oe cleared", {16'h0, pin_oe}, 32'h0);
    check("R3 pin_out cleared", {16'h0, pin_out}, 32'h0);
    check("R9 shared quiet in reset", {31'h0, irq_shared}, 32'h0);
    bus_write(3'd1, 32'h0000_FFFF);
    bus_read(3'd0, v);
    check("R2 ctl readback reset", v, 32'h3);
    bus_write(3'd0, 32'h1);
    check("R3 write during reset ignored", {16'h0, pin_oe}, 32'h0);
    bus_read(3'd4, v);
    check("R3 enables cleared", v, 32'h0);
    bus_write(3'd0, 32'h2);
    bus_read(3'd0, v);
    check("R2 ctl readback value 2", v, 32'h2);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_stopped_writes();
    t_direction();
    t_masked_out();
    t_pin_state();
    t_irqs();
    t_clock_hold();
    t_soft_reset();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule